// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block turns a master audio clock into the serial bit clock and two frame (left/right select) clocks that a serial audio transmitter and receiver need. In master mode it divides the master clock by a programmable integer to form the bit clock. It then divides the bit clock separately for the transmit and the receive path to form each path's frame clock. Alongside the clocks it produces single-cycle enable strobes in the master clock domain. These tell the serializers when to launch data (at a falling bit-clock edge) and when to capture it (at a rising edge), and when a new frame begins.

In slave mode the block stops driving its clock pins and lowers the output enable. It synchronizes externally supplied bit and frame clocks through a flop chain and turns their edges into the same set of enable strobes. Configuration arrives as one 32-bit control word. Each divider field holds its ratio minus one. A new word takes effect only at the end of the current bit-clock period, so a reprogram never shortens a clock phase that is already under way.

The block has no data stream. All of its pins are plain control and status signals, with no valid/ready handshake and no back-pressure. The strobes are single-cycle pulses and the serializers must accept them in the cycle they are issued.

Top module: `audclk_gen`

## Requirements
- R1: In master mode the bit clock period is N master-clock cycles, where N is control bits [23:16] plus one (a field of 0 acts as 1, giving N=2). The bit clock is high for floor(N/2) cycles and low for the rest.
- R2: The transmit frame clock spans F bit periods, where F is control bits [7:0] plus one (a field of 0 acts as 1). It is low for floor(F/2) bit periods and high for the remainder, and it changes only together with a launch strobe.
- R3: The receive frame clock follows the same rule with F taken from control bits [15:8], independently of the transmit field.
- R4: Control bit 26 set inverts the bit clock seen at the pin, so the pin is high for N-floor(N/2) cycles and low for floor(N/2).
- R5: The launch strobe pulses for one cycle at each falling edge of the internal (non-inverted) bit clock, and the capture strobe at each rising edge. The two are never high together.
- R6: Each frame-start strobe pulses together with the launch strobe on the bit where its frame clock returns low. Exactly F launch strobes (transmit) or F capture strobes (receive) occur from one frame start to the next.
- R7: During reset the active configuration is the reset word (master, N=4, F=64 for both paths), the clock output enable is high, and all clocks and strobes are low.
- R8: A control write takes effect at the end of the current bit period. The running high and low phases finish at their old lengths, and the frame counters then restart with the frame clocks low.
- R9: Control bit 27 set selects slave mode. The clock output enable and the clock outputs go low, and the bit strobes follow the external bit clock's edges with a latency of three master-clock cycles.
- R10: In slave mode each frame-start strobe pulses once per falling edge of that path's external frame clock. Bit 26 swaps which external bit-clock edge counts as rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_tx_lrck_i | input | 1 | External transmit frame clock (slave mode) |
| ext_rx_lrck_i | input | 1 | External receive frame clock (slave mode) |
| clk_oe_o | output | 1 | High while the block drives its clock pins |
| bclk_o | output | 1 | Bit clock pin |
| tx_lrck_o | output | 1 | Transmit frame clock pin |
| rx_lrck_o | output | 1 | Receive frame clock pin |
| tx_bit_en_o | output | 1 | Launch strobe (falling bit edge) |
| rx_bit_en_o | output | 1 | Capture strobe (rising bit edge) |
| tx_frame_en_o | output | 1 | Transmit frame-start strobe |
| rx_frame_en_o | output | 1 | Receive frame-start strobe |

## Verification
The assertions check a set of relations on every cycle in master mode:
- the launch and capture strobes never coincide;
- each strobe sits on the matching edge of the internal bit clock;
- a frame start always arrives with a launch strobe and a low frame clock;
- a frame clock moves only with a launch strobe, except at a reload;
- the bit clock stays parked in slave mode.

The actual phase lengths cannot be seen from a single cycle, so the bench's scenarios measure them for each divider setting. The same holds for the odd-ratio rounding, the polarity inversion, the deferred reload during a running phase, and the three-cycle slave latency with its edge-sense swap.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int CFG_W     = 32;
  localparam int DIV_W     = 8;
  localparam int SLAVE_BIT = 27;
  localparam int INV_BIT   = 26;
  localparam int MDIV_LSB  = 16;
  localparam int RXDIV_LSB = 8;
  localparam int TXDIV_LSB = 0;

  typedef struct packed {
    logic             slave;
    logic             inv;
    logic [DIV_W-1:0] mdiv;
    logic [DIV_W-1:0] rxdiv;
    logic [DIV_W-1:0] txdiv;
  } audclk_cfg_t;

  // A ratio of one cannot be produced by a registered clock; treat it as two.
  function automatic logic [DIV_W-1:0] clamp_last(input logic [DIV_W-1:0] f);
    return (f == '0) ? DIV_W'(1) : f;
  endfunction

  function automatic logic [DIV_W:0] half_of(input logic [DIV_W-1:0] last);
    return ({1'b0, last} + (DIV_W+1)'(1)) >> 1;
  endfunction
endpackage

// File: rtl/audclk_cfg_reg.sv
module audclk_cfg_reg
  import audclk_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 32'h0003_3F3F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             at_last_i,
  output audclk_cfg_t      act_o,
  output logic             load_o
);
  localparam audclk_cfg_t RST_C = '{
    slave: RESET_CFG[SLAVE_BIT],
    inv:   RESET_CFG[INV_BIT],
    mdiv:  RESET_CFG[MDIV_LSB +: DIV_W],
    rxdiv: RESET_CFG[RXDIV_LSB +: DIV_W],
    txdiv: RESET_CFG[TXDIV_LSB +: DIV_W]
  };

  audclk_cfg_t shadow_q, act_q, wr_c;
  logic        pend_q;
  logic        unused_bits;

  assign wr_c = '{
    slave: wdata_i[SLAVE_BIT],
    inv:   wdata_i[INV_BIT],
    mdiv:  wdata_i[MDIV_LSB +: DIV_W],
    rxdiv: wdata_i[RXDIV_LSB +: DIV_W],
    txdiv: wdata_i[TXDIV_LSB +: DIV_W]
  };
  assign unused_bits = ^{wdata_i[31:28], wdata_i[25:24]};

  // In slave mode no bit period runs, so a pending word loads at once.
  assign load_o = pend_q && (act_q.slave || at_last_i);
  assign act_o  = act_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      shadow_q <= RST_C;
      act_q    <= RST_C;
      pend_q   <= 1'b0;
    end else begin
      if (load_o) act_q <= shadow_q;
      if (we_i) begin
        shadow_q <= wr_c;
        pend_q   <= 1'b1;
      end else if (load_o) begin
        pend_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audclk_bitgen.sv
module audclk_bitgen
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] last_i,
  output logic             bclk_q_o,
  output logic             fall_evt_o,
  output logic             rise_q_o,
  output logic             fall_q_o,
  output logic             at_last_o
);
  logic [DIV_W-1:0] cnt_q, last_c;
  logic [DIV_W:0]   half_c;
  logic             rise_evt;

  assign last_c     = clamp_last(last_i);
  assign half_c     = half_of(last_c);
  assign at_last_o  = master_i && (cnt_q >= last_c);
  assign rise_evt   = master_i && (cnt_q == '0);
  assign fall_evt_o = master_i && ({1'b0, cnt_q} == half_c);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !master_i) begin
      cnt_q    <= '0;
      bclk_q_o <= 1'b0;
      rise_q_o <= 1'b0;
      fall_q_o <= 1'b0;
    end else begin
      cnt_q    <= at_last_o ? '0 : cnt_q + DIV_W'(1);
      rise_q_o <= rise_evt;
      fall_q_o <= fall_evt_o;
      if (rise_evt)        bclk_q_o <= 1'b1;
      else if (fall_evt_o) bclk_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audclk_framediv.sv
module audclk_framediv
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] last_i,
  output logic             lrck_o,
  output logic             frame_o
);
  logic [DIV_W-1:0] fc_q, fc_next, last_c;
  logic [DIV_W:0]   half_c;

  assign last_c  = clamp_last(last_i);
  assign half_c  = half_of(last_c);
  assign fc_next = (fc_q >= last_c) ? '0 : fc_q + DIV_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || restart_i) begin
      fc_q    <= '0;
      lrck_o  <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      frame_o <= step_i && (fc_next == '0);
      if (step_i) begin
        fc_q   <= fc_next;
        lrck_o <= ({1'b0, fc_next} >= half_c);
      end
    end
  end
endmodule

// File: rtl/audclk_slave_edges.sv
module audclk_slave_edges #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inv_i,
  input  logic ext_bclk_i,
  input  logic ext_tx_lrck_i,
  input  logic ext_rx_lrck_i,
  output logic rise_q_o,
  output logic fall_q_o,
  output logic txf_q_o,
  output logic rxf_q_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] in_c, cur_c, prev_c;
  logic            b_now, b_prev;

  assign in_c = {ext_rx_lrck_i, ext_tx_lrck_i, ext_bclk_i};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], in_c[i]};
        prev_q  <= chain_q[SYNC_STAGES-1];
      end
    end
    assign cur_c[i]  = chain_q[SYNC_STAGES-1];
    assign prev_c[i] = prev_q;
  end

  assign b_now  = cur_c[0] ^ inv_i;
  assign b_prev = prev_c[0] ^ inv_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rise_q_o <= 1'b0;
      fall_q_o <= 1'b0;
      txf_q_o  <= 1'b0;
      rxf_q_o  <= 1'b0;
    end else begin
      rise_q_o <= b_now & ~b_prev;
      fall_q_o <= ~b_now & b_prev;
      txf_q_o  <= ~cur_c[1] & prev_c[1];
      rxf_q_o  <= ~cur_c[2] & prev_c[2];
    end
  end
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter logic [31:0] RESET_CFG   = 32'h0003_3F3F,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        ext_bclk_i,
  input  logic        ext_tx_lrck_i,
  input  logic        ext_rx_lrck_i,
  output logic        clk_oe_o,
  output logic        bclk_o,
  output logic        tx_lrck_o,
  output logic        rx_lrck_o,
  output logic        tx_bit_en_o,
  output logic        rx_bit_en_o,
  output logic        tx_frame_en_o,
  output logic        rx_frame_en_o
);
  localparam int NPATH = 2;

  audclk_cfg_t act;
  logic        cfg_load, master, at_last;
  logic        bclk_int, fall_evt, m_rise, m_fall;
  logic [NPATH-1:0] lrck_w, frame_w;
  logic        s_rise, s_fall, s_txf, s_rxf;

  assign master = ~act.slave;

  audclk_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .at_last_i(at_last), .act_o(act), .load_o(cfg_load)
  );

  audclk_bitgen u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master), .last_i(act.mdiv),
    .bclk_q_o(bclk_int), .fall_evt_o(fall_evt), .rise_q_o(m_rise),
    .fall_q_o(m_fall), .at_last_o(at_last)
  );

  // Path 0 transmits, path 1 receives; both advance on the falling bit edge.
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    audclk_framediv u_frame (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(cfg_load), .step_i(fall_evt),
      .last_i((p == 0) ? act.txdiv : act.rxdiv),
      .lrck_o(lrck_w[p]), .frame_o(frame_w[p])
    );
  end

  audclk_slave_edges #(.SYNC_STAGES(SYNC_STAGES)) u_slv (
    .clk_i(clk_i), .rst_ni(rst_ni), .inv_i(act.inv),
    .ext_bclk_i(ext_bclk_i), .ext_tx_lrck_i(ext_tx_lrck_i), .ext_rx_lrck_i(ext_rx_lrck_i),
    .rise_q_o(s_rise), .fall_q_o(s_fall), .txf_q_o(s_txf), .rxf_q_o(s_rxf)
  );

  assign clk_oe_o      = master;
  assign bclk_o        = master & (bclk_int ^ act.inv);
  assign tx_lrck_o     = master & lrck_w[0];
  assign rx_lrck_o     = master & lrck_w[1];
  assign tx_bit_en_o   = master ? m_fall     : s_fall;
  assign rx_bit_en_o   = master ? m_rise     : s_rise;
  assign tx_frame_en_o = master ? frame_w[0] : s_txf;
  assign rx_frame_en_o = master ? frame_w[1] : s_rxf;
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_oe_o,
  input logic tx_lrck_o,
  input logic rx_lrck_o,
  input logic tx_bit_en_o,
  input logic rx_bit_en_o,
  input logic tx_frame_en_o,
  input logic rx_frame_en_o,
  input logic bclk_int,
  input logic reload
);
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_bit_en_o, rx_bit_en_o}));

  assert_fall_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && tx_bit_en_o |-> !bclk_int && $past(bclk_int));

  assert_rise_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && rx_bit_en_o |-> bclk_int && !$past(bclk_int));

  assert_tx_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && tx_frame_en_o |-> tx_bit_en_o && !tx_lrck_o);

  assert_rx_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && rx_frame_en_o |-> tx_bit_en_o && !rx_lrck_o);

  assert_tx_lrck_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && $past(clk_oe_o) && !$past(reload) && (tx_lrck_o != $past(tx_lrck_o))
      |-> tx_bit_en_o);

  assert_rx_lrck_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o && $past(clk_oe_o) && !$past(reload) && (rx_lrck_o != $past(rx_lrck_o))
      |-> tx_bit_en_o);

  assert_slave_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe_o && !$past(clk_oe_o) |-> !bclk_int);
endmodule

bind audclk_gen audclk_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_oe_o(clk_oe_o),
  .tx_lrck_o(tx_lrck_o), .rx_lrck_o(rx_lrck_o),
  .tx_bit_en_o(tx_bit_en_o), .rx_bit_en_o(rx_bit_en_o),
  .tx_frame_en_o(tx_frame_en_o), .rx_frame_en_o(rx_frame_en_o),
  .bclk_int(bclk_int), .reload(cfg_load)
);

// File: tb/audclk_gen_bench.sv
module audclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        ext_bclk = 1'b0, ext_tx_lrck = 1'b0, ext_rx_lrck = 1'b0;
  logic        clk_oe, bclk, tx_lrck, rx_lrck, tx_bit_en, rx_bit_en, tx_frame_en, rx_frame_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audclk_gen u_audclk_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .ext_bclk_i(ext_bclk), .ext_tx_lrck_i(ext_tx_lrck), .ext_rx_lrck_i(ext_rx_lrck),
    .clk_oe_o(clk_oe), .bclk_o(bclk), .tx_lrck_o(tx_lrck), .rx_lrck_o(rx_lrck),
    .tx_bit_en_o(tx_bit_en), .rx_bit_en_o(rx_bit_en),
    .tx_frame_en_o(tx_frame_en), .rx_frame_en_o(rx_frame_en)
  );

  // Control words and expected {bclk hi, bclk lo, tx lo, tx hi, rx lo, rx hi} in master cycles.
  localparam int NV = 6;
  localparam logic [31:0] VCFG [NV] = '{
    32'h0003_3F3F, 32'h0002_0F1F, 32'h0007_1F0F,
    32'h0004_0904, 32'h0000_0000, 32'h0402_0F1F
  };
  localparam int VEXP [NV][6] = '{
    '{2, 2, 128, 128, 128, 128},
    '{1, 2,  48,  48,  24,  24},
    '{4, 4,  64,  64, 128, 128},
    '{2, 3,  10,  15,  25,  25},
    '{1, 1,   2,   2,   2,   2},
    '{2, 1,  48,  48,  24,  24}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic sig(input int s);
    case (s)
      0:       return bclk;
      1:       return tx_lrck;
      default: return rx_lrck;
    endcase
  endfunction

  // Phase lengths of one full period, sampled once per cycle at the falling edge.
  task automatic measure(input int s, output int hi, output int lo);
    int guard = 0;
    while (sig(s) !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (sig(s) !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    hi = 0;
    while (sig(s) === 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
    lo = 0;
    while (sig(s) === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    finish_run();
  end

  initial begin
    int hi, lo, cnt, guard;

    // R7: reset state
    repeat (4) @(negedge clk);
    check("R7 clk_oe in reset", clk_oe, 1);
    check("R7 bclk in reset", bclk, 0);
    check("R7 lrck in reset", {tx_lrck, rx_lrck}, 0);
    check("R7 strobes in reset", {tx_bit_en, rx_bit_en, tx_frame_en, rx_frame_en}, 0);
    rst_n = 1'b1;

    // R7 default divide and R5 strobe edges
    measure(0, hi, lo);
    check("R7 default bclk hi", hi, 2);
    check("R7 default bclk lo", lo, 2);
    guard = 0;
    while (tx_bit_en !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    check("R5 launch strobe at bclk low", bclk, 0);
    guard = 0;
    while (rx_bit_en !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    check("R5 capture strobe at bclk high", bclk, 1);
    check("R5 no launch with capture", tx_bit_en, 0);

    // Vector table: R1 bit clock, R2/R3 frame clocks, R4 inversion (last row)
    for (int v = 0; v < NV; v++) begin
      write_cfg(VCFG[v]);
      repeat (600) @(negedge clk);
      measure(0, hi, lo);
      check($sformatf("R1/R4 v%0d bclk hi", v), hi, VEXP[v][0]);
      check($sformatf("R1/R4 v%0d bclk lo", v), lo, VEXP[v][1]);
      measure(1, hi, lo);
      check($sformatf("R2 v%0d tx lrck lo", v), lo, VEXP[v][2]);
      check($sformatf("R2 v%0d tx lrck hi", v), hi, VEXP[v][3]);
      measure(2, hi, lo);
      check($sformatf("R3 v%0d rx lrck lo", v), lo, VEXP[v][4]);
      check($sformatf("R3 v%0d rx lrck hi", v), hi, VEXP[v][5]);
    end

    // R6: strobes per frame with tx F=32, rx F=16
    guard = 0;
    while (tx_frame_en !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    cnt = 0;
    do begin @(negedge clk); if (tx_bit_en) cnt++; guard++; end
    while (tx_frame_en !== 1'b1 && guard < 4000);
    check("R6 launch strobes per tx frame", cnt, 32);
    guard = 0;
    while (rx_frame_en !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    cnt = 0;
    do begin @(negedge clk); if (rx_bit_en) cnt++; guard++; end
    while (rx_frame_en !== 1'b1 && guard < 4000);
    check("R6 capture strobes per rx frame", cnt, 16);

    // R8: rewrite while the bit clock is high; old phases finish intact
    write_cfg(32'h0007_3F3F);
    repeat (600) @(negedge clk);
    guard = 0;
    while (bclk !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
    while (bclk !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    cfg_we = 1'b1; cfg_wdata = 32'h0003_3F3F;
    hi = 1;
    @(negedge clk);
    cfg_we = 1'b0;
    while (bclk === 1'b1 && guard < 400) begin hi++; @(negedge clk); guard++; end
    lo = 0;
    while (bclk === 1'b0 && guard < 400) begin lo++; @(negedge clk); guard++; end
    check("R8 old high phase kept", hi, 4);
    check("R8 old low phase kept", lo, 4);
    check("R8 frame restarts low", tx_lrck, 0);
    measure(0, hi, lo);
    check("R8 new bclk hi", hi, 2);
    check("R8 new bclk lo", lo, 2);

    // R9: slave mode
    write_cfg(32'h0800_0000);
    repeat (20) @(negedge clk);
    check("R9 clk_oe low in slave", clk_oe, 0);
    check("R9 clocks low in slave", {bclk, tx_lrck, rx_lrck}, 0);
    begin
      int nr = 0, nf = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (rx_bit_en) nr++;
        if (tx_bit_en) nf++;
        ext_bclk = (i < 80) && ((i / 4) % 2 == 1);
      end
      check("R9 capture strobes per external rise", nr, 10);
      check("R9 launch strobes per external fall", nf, 10);
    end
    ext_bclk = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 capture not before latency", rx_bit_en, 0);
    @(negedge clk);
    check("R9 capture after three cycles", rx_bit_en, 1);
    ext_bclk = 1'b0;
    repeat (10) @(negedge clk);

    // R10: slave frame strobes and edge-sense swap
    begin
      int ntx = 0, nrx = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_frame_en) ntx++;
        if (rx_frame_en) nrx++;
        ext_tx_lrck = (i < 10);
      end
      check("R10 tx frame strobe per external fall", ntx, 1);
      check("R10 rx frame strobe absent", nrx, 0);
    end
    write_cfg(32'h0C00_0000);
    repeat (5) @(negedge clk);
    ext_bclk = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 inverted rise gives launch", tx_bit_en, 1);
    check("R10 inverted rise gives no capture", rx_bit_en, 0);

    finish_run();
  end
endmodule